// File: doc/BRIEF.md
# Justified Stream Demultiplexer and Destuffer

This block takes one higher-rate serial line, one bit per clock, made of fixed-length frames that carry four bit-interleaved tributaries with positive justification. It finds the frame boundary and keeps track of it, then skips the fixed overhead fields and hands each payload bit to its tributary in strict rotation. For each tributary it also decides whether that frame's justification slot holds real data or a stuff bit to throw away.

Each frame has this layout, counted from bit 0:
- The alignment pattern, FAW_W bits, sent most significant bit first.
- SVC_W service bits.
- CTL_REP groups of NT control bits. Within each group the lanes follow in the order 0 to NT-1.
- NT justification slots, one per lane, in lane order.
- NT*DPT data bits, also in lane rotation starting at lane 0.

Each tributary comes out as a data bit plus a one-cycle valid strobe. The strobe has regular holes where overhead sits and irregular holes where a stuff bit was removed. A downstream clock-smoothing stage turns these gapped strobes into even tributary clocks. The service bits of the last aligned frame are held in an output register.

Top module: `pdh_dmx_top`

## Requirements
- R1: While reset is high and just after it is released, `locked` is 0, every `trib_vld` bit is 0 and `svc_bits` is 0.
- R2: Lock needs the alignment pattern at the expected place in CONFIRM consecutive frames (default 3). Searching restarts whenever an expected pattern is missing before lock. `locked` rises in the cycle after the last bit of the confirming pattern.
- R3: Once locked, lock is dropped only after MISS_LIMIT consecutive frames (default 4) lack the pattern. A single good frame clears the miss count. `locked` falls in the cycle after the last bit of the final missing pattern.
- R4: While `locked` is 0, no `trib_vld` bit is ever 1.
- R5: No valid strobe is produced for alignment, service or control positions. At most one `trib_vld` bit is high in any cycle. Payload bit k after the control field goes to lane k mod NT.
- R6: Each tributary's delivered bits are exactly its transmitted data bits, in order, with nothing missing or added.
- R7: A control bit of 1 means "stuffed". A lane's justification slot is delivered only when the majority of its CTL_REP control bits in that frame is 0. Each locked frame therefore yields DPT+1 or DPT valid strobes per lane, and one corrupted control bit changes nothing.
- R8: `svc_bits` loads the service field of a frame in which the block is locked, with the first received bit as the MSB, in the cycle after the last service bit. At all other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| line_bit | input | 1 | Incoming justified line bit |
| trib_bit | output | NT | Recovered bit, one per tributary |
| trib_vld | output | NT | Gapped strobe marking a new recovered bit per tributary |
| svc_bits | output | SVC_W | Service field of the last locked frame |
| locked | output | 1 | Frame alignment is held |

## Verification
The assertions check on every cycle that there are no strobes while unlocked or on overhead positions, that the lanes are exclusive, and that the service register holds while unlocked. They also check that lock changes only at the confirmation count or at the miss limit.

Only the bench scenarios can show that the recovered bit sequences match the transmitted ones. The same holds for the per-frame stuff vote when a control bit is corrupted, and for the exact cycle at which lock is gained, kept through three bad patterns, lost and regained.

// File: rtl/pdh_dmx_pkg.sv
package pdh_dmx_pkg;
  typedef enum logic [1:0] {
    AL_HUNT    = 2'd0,
    AL_PRESYNC = 2'd1,
    AL_SYNC    = 2'd2
  } align_state_e;
endpackage

// File: rtl/pdh_dmx_align.sv
// Frame alignment: position counter plus hunt/presync/sync state machine.
module pdh_dmx_align
  import pdh_dmx_pkg::*;
#(
  parameter int FAW_W      = 8,
  parameter logic [FAW_W-1:0] FAW_PAT = 8'hD2,
  parameter int FRAME_LEN  = 76,
  parameter int CONFIRM    = 3,
  parameter int MISS_LIMIT = 4,
  parameter int PW         = 7,
  parameter int CW         = 2,
  parameter int MW         = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_i,
  output logic [PW-1:0] pos_o,
  output align_state_e  state_o,
  output logic          locked_o,
  output logic [CW-1:0] hit_o,
  output logic [MW-1:0] miss_o
);
  localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);
  localparam logic [PW-1:0] FAW_END  = PW'(FAW_W - 1);
  localparam logic [PW-1:0] AFTER_FAW = PW'(FAW_W);
  localparam logic [CW-1:0] CONF_M1  = CW'(CONFIRM - 1);
  localparam logic [MW-1:0] MISS_M1  = MW'(MISS_LIMIT - 1);

  logic [FAW_W-1:0] win_q;
  logic [FAW_W-1:0] window;
  logic             match;
  logic [PW-1:0]    pos_q, pos_d;
  align_state_e     st_q, st_d;
  logic [CW-1:0]    hit_q, hit_d;
  logic [MW-1:0]    miss_q, miss_d;
  logic             locked_q;
  logic             faw_end;

  assign window  = {win_q[FAW_W-2:0], bit_i};
  assign match   = (window == FAW_PAT);
  assign faw_end = (pos_q == FAW_END);

  always_comb begin
    pos_d  = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    st_d   = st_q;
    hit_d  = hit_q;
    miss_d = miss_q;
    unique case (st_q)
      AL_HUNT: begin
        if (match) begin
          pos_d  = AFTER_FAW;
          hit_d  = CW'(1);
          miss_d = '0;
          st_d   = (CONFIRM == 1) ? AL_SYNC : AL_PRESYNC;
        end
      end
      AL_PRESYNC: begin
        if (faw_end) begin
          if (match) begin
            if (hit_q == CONF_M1) begin
              st_d   = AL_SYNC;
              miss_d = '0;
            end else begin
              hit_d = hit_q + 1'b1;
            end
          end else begin
            st_d  = AL_HUNT;
            hit_d = '0;
          end
        end
      end
      AL_SYNC: begin
        if (faw_end) begin
          if (match) begin
            miss_d = '0;
          end else if (miss_q == MISS_M1) begin
            st_d   = AL_HUNT;
            miss_d = '0;
            hit_d  = '0;
          end else begin
            miss_d = miss_q + 1'b1;
          end
        end
      end
      default: st_d = AL_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= '0;
      pos_q    <= '0;
      st_q     <= AL_HUNT;
      hit_q    <= '0;
      miss_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      win_q    <= window;
      pos_q    <= pos_d;
      st_q     <= st_d;
      hit_q    <= hit_d;
      miss_q   <= miss_d;
      locked_q <= (st_d == AL_SYNC);
    end
  end

  assign pos_o    = pos_q;
  assign state_o  = st_q;
  assign locked_o = locked_q;
  assign hit_o    = hit_q;
  assign miss_o   = miss_q;
endmodule

// File: rtl/pdh_dmx_vote.sv
// Per-lane count of control bits set; majority gives the stuff decision.
module pdh_dmx_vote #(
  parameter int NT       = 4,
  parameter int CTL_REP  = 3,
  parameter int PW       = 7,
  parameter int TW       = 2,
  parameter int CLR_POS  = 8,
  parameter int CTL_BASE = 12,
  parameter int STF_BASE = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_i,
  input  logic [PW-1:0] pos_i,
  input  logic [TW-1:0] lane_i,
  output logic [NT-1:0] stuff_o
);
  localparam int VW = $clog2(CTL_REP + 1);
  localparam logic [VW-1:0] HALF   = VW'(CTL_REP / 2);
  localparam logic [PW-1:0] CLR_P  = PW'(CLR_POS);
  localparam logic [PW-1:0] CTL_LO = PW'(CTL_BASE);
  localparam logic [PW-1:0] CTL_HI = PW'(STF_BASE);

  logic [VW-1:0] cnt_q [NT];
  logic          in_ctl;

  assign in_ctl = (pos_i >= CTL_LO) && (pos_i < CTL_HI);

  always_ff @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (rst || pos_i == CLR_P) begin
        cnt_q[t] <= '0;
      end else if (in_ctl && bit_i && lane_i == TW'(t)) begin
        cnt_q[t] <= cnt_q[t] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_dec
    assign stuff_o[g] = (cnt_q[g] > HALF);
  end
endmodule

// File: rtl/pdh_dmx_lanes.sv
// Payload steering, stuff drop and service capture; all outputs registered.
module pdh_dmx_lanes #(
  parameter int NT       = 4,
  parameter int TW       = 2,
  parameter int PW       = 7,
  parameter int SVC_W    = 4,
  parameter int SVC_BASE = 8,
  parameter int STF_BASE = 24,
  parameter int DAT_BASE = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_i,
  input  logic [PW-1:0]    pos_i,
  input  logic [TW-1:0]    lane_i,
  input  logic             in_sync_i,
  input  logic [NT-1:0]    stuff_i,
  output logic [NT-1:0]    trib_bit_o,
  output logic [NT-1:0]    trib_vld_o,
  output logic [SVC_W-1:0] svc_o
);
  localparam logic [PW-1:0] SVC_LO   = PW'(SVC_BASE);
  localparam logic [PW-1:0] SVC_LAST = PW'(SVC_BASE + SVC_W - 1);
  localparam logic [PW-1:0] STF_LO   = PW'(STF_BASE);
  localparam logic [PW-1:0] DAT_LO   = PW'(DAT_BASE);

  logic [SVC_W-1:0] svc_sh_q, svc_q;
  logic [SVC_W:0]   svc_cat;
  logic             in_svc, is_stf, is_dat, take;
  logic [NT-1:0]    bit_q, vld_q;

  assign svc_cat = {svc_sh_q, bit_i};
  assign in_svc  = (pos_i >= SVC_LO) && (pos_i <= SVC_LAST);
  assign is_stf  = (pos_i >= STF_LO) && (pos_i < DAT_LO);
  assign is_dat  = (pos_i >= DAT_LO);
  assign take    = in_sync_i && (is_dat || (is_stf && !stuff_i[lane_i]));

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_sh_q <= '0;
      svc_q    <= '0;
    end else begin
      if (in_svc) svc_sh_q <= svc_cat[SVC_W-1:0];
      if (in_sync_i && pos_i == SVC_LAST) svc_q <= svc_cat[SVC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (rst) begin
        vld_q[t] <= 1'b0;
        bit_q[t] <= 1'b0;
      end else begin
        vld_q[t] <= take && (lane_i == TW'(t));
        if (take && lane_i == TW'(t)) bit_q[t] <= bit_i;
      end
    end
  end

  assign trib_bit_o = bit_q;
  assign trib_vld_o = vld_q;
  assign svc_o      = svc_q;
endmodule

// File: rtl/pdh_dmx_top.sv
module pdh_dmx_top
  import pdh_dmx_pkg::*;
#(
  parameter int NT         = 4,
  parameter int FAW_W      = 8,
  parameter logic [FAW_W-1:0] FAW_PAT = 8'hD2,
  parameter int SVC_W      = 4,
  parameter int CTL_REP    = 3,
  parameter int DPT        = 12,
  parameter int CONFIRM    = 3,
  parameter int MISS_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_bit,
  output logic [NT-1:0]    trib_bit,
  output logic [NT-1:0]    trib_vld,
  output logic [SVC_W-1:0] svc_bits,
  output logic             locked
);
  localparam int SVC_BASE  = FAW_W;
  localparam int CTL_BASE  = SVC_BASE + SVC_W;
  localparam int STF_BASE  = CTL_BASE + CTL_REP * NT;
  localparam int DAT_BASE  = STF_BASE + NT;
  localparam int FRAME_LEN = DAT_BASE + NT * DPT;
  localparam int PW = $clog2(FRAME_LEN);
  localparam int TW = $clog2(NT);
  localparam int CW = $clog2(CONFIRM + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam logic [PW-1:0] LANE_CLR  = PW'(CTL_BASE - 1);
  localparam logic [TW-1:0] LANE_LAST = TW'(NT - 1);

  logic [PW-1:0] pos_w;
  align_state_e  state_w;
  logic [CW-1:0] hit_w;
  logic [MW-1:0] miss_w;
  logic [TW-1:0] lane_q;
  logic [NT-1:0] stuff_w;
  logic          in_sync;

  pdh_dmx_align #(
    .FAW_W(FAW_W), .FAW_PAT(FAW_PAT), .FRAME_LEN(FRAME_LEN),
    .CONFIRM(CONFIRM), .MISS_LIMIT(MISS_LIMIT), .PW(PW), .CW(CW), .MW(MW)
  ) u_align (
    .clk(clk), .rst(rst), .bit_i(line_bit), .pos_o(pos_w), .state_o(state_w),
    .locked_o(locked), .hit_o(hit_w), .miss_o(miss_w)
  );

  // Lane rotation: lane 0 at the first control bit; all later fields are NT multiples.
  always_ff @(posedge clk) begin
    if (rst || pos_w == LANE_CLR) lane_q <= '0;
    else if (lane_q == LANE_LAST) lane_q <= '0;
    else lane_q <= lane_q + 1'b1;
  end

  assign in_sync = (state_w == AL_SYNC);

  pdh_dmx_vote #(
    .NT(NT), .CTL_REP(CTL_REP), .PW(PW), .TW(TW),
    .CLR_POS(SVC_BASE), .CTL_BASE(CTL_BASE), .STF_BASE(STF_BASE)
  ) u_vote (
    .clk(clk), .rst(rst), .bit_i(line_bit), .pos_i(pos_w), .lane_i(lane_q),
    .stuff_o(stuff_w)
  );

  pdh_dmx_lanes #(
    .NT(NT), .TW(TW), .PW(PW), .SVC_W(SVC_W), .SVC_BASE(SVC_BASE),
    .STF_BASE(STF_BASE), .DAT_BASE(DAT_BASE)
  ) u_lanes (
    .clk(clk), .rst(rst), .bit_i(line_bit), .pos_i(pos_w), .lane_i(lane_q),
    .in_sync_i(in_sync), .stuff_i(stuff_w), .trib_bit_o(trib_bit),
    .trib_vld_o(trib_vld), .svc_o(svc_bits)
  );
endmodule

// File: rtl/pdh_dmx_chk.sv
module pdh_dmx_chk #(
  parameter int NT = 4, parameter int SVC_W = 4, parameter int PW = 7,
  parameter int CW = 2, parameter int MW = 3, parameter int STF_BASE = 24,
  parameter int CONFIRM = 3, parameter int MISS_LIMIT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             locked,
  input logic [NT-1:0]    trib_vld,
  input logic [SVC_W-1:0] svc_bits,
  input logic [PW-1:0]    pos,
  input logic [CW-1:0]    hit_cnt,
  input logic [MW-1:0]    miss_cnt
);
  localparam logic [PW-1:0] STF_LO  = PW'(STF_BASE);
  localparam logic [CW-1:0] CONF_M1 = CW'(CONFIRM - 1);
  localparam logic [MW-1:0] MISS_M1 = MW'(MISS_LIMIT - 1);

  a_r4_quiet_unlocked: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (trib_vld == '0));
  a_r5_one_lane: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trib_vld));
  a_r5_overhead_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(pos) < STF_LO) |-> (trib_vld == '0));
  a_r8_svc_hold: assert property (@(posedge clk) disable iff (rst)
    !locked |=> $stable(svc_bits));
  a_r2_confirm_count: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(hit_cnt) == CONF_M1));
  a_r3_miss_count: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(miss_cnt) == MISS_M1));
endmodule

bind pdh_dmx_top pdh_dmx_chk #(
  .NT(NT), .SVC_W(SVC_W), .PW(PW), .CW(CW), .MW(MW), .STF_BASE(STF_BASE),
  .CONFIRM(CONFIRM), .MISS_LIMIT(MISS_LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .locked(locked), .trib_vld(trib_vld),
  .svc_bits(svc_bits), .pos(pos_w), .hit_cnt(hit_w), .miss_cnt(miss_w)
);

// File: tb/pdh_dmx_top_test.sv
module pdh_dmx_top_test;
  localparam int NT = 4, FAW_W = 8, SVC_W = 4, CTL_REP = 3, DPT = 12;
  localparam logic [FAW_W-1:0] FAW = 8'hD2;
  localparam int SVC_BASE = FAW_W, CTL_BASE = SVC_BASE + SVC_W;
  localparam int STF_BASE = CTL_BASE + CTL_REP * NT, DAT_BASE = STF_BASE + NT;
  localparam int FL = DAT_BASE + NT * DPT;
  localparam int NFR = 36;

  logic clk = 0, rst = 1, line_bit = 0;
  logic [NT-1:0] trib_bit, trib_vld;
  logic [SVC_W-1:0] svc_bits;
  logic locked;

  pdh_dmx_top uut (.clk(clk), .rst(rst), .line_bit(line_bit), .trib_bit(trib_bit),
                   .trib_vld(trib_vld), .svc_bits(svc_bits), .locked(locked));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int txidx[NT], rxidx[NT], fcnt[NT];
  int base_idx[NFR][NT];
  int prv_f, prv_pos;
  bit have_prev = 0, sync_start = 0, lk_prev = 0, done = 0;
  logic [SVC_W-1:0] last_svc = '0;

  function automatic logic src_bit(int t, int n);
    int h;
    h = n * 37 + t * 101 + (n >> 2) * 13;
    return h[2] ^ h[5];
  endfunction
  function automatic bit stf(int t, int f);
    return ((f + t) % 3) == 0;
  endfunction
  function automatic bit ctl_err(int t, int f, int g);
    return (f % 2 == 1) && (t == f % NT) && (g == f % 3);
  endfunction
  function automatic logic [SVC_W-1:0] svc_of(int f);
    return SVC_W'(f * 5 + 3);
  endfunction
  function automatic bit exp_lock(int f, int p);
    int g;
    g = f * FL + p;
    return (g >= 2 * FL + FAW_W - 1 && g < 27 * FL + FAW_W - 1) || (g >= 30 * FL + FAW_W - 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (frame %0d bit %0d)",
               req, what, act, exp, prv_f, prv_pos);
    end
  endtask

  task automatic observe();
    bit el;
    if (!have_prev) return;
    el = exp_lock(prv_f, prv_pos);
    chk(locked == el, (prv_f < 20) ? "R2" : "R3", "locked", locked, el);
    if (!el) chk(trib_vld == '0, "R4", "valid while unlocked", trib_vld, 0);
    if (el && prv_pos < STF_BASE) chk(trib_vld == '0, "R5", "valid on overhead", trib_vld, 0);
    if (locked && !lk_prev) for (int t = 0; t < NT; t++) rxidx[t] = base_idx[prv_f][t];
    lk_prev = locked;
    for (int t = 0; t < NT; t++) begin
      if (trib_vld[t]) begin
        chk(trib_bit[t] == src_bit(t, rxidx[t]), "R6", $sformatf("lane %0d bit %0d", t, rxidx[t]),
            trib_bit[t], src_bit(t, rxidx[t]));
        rxidx[t]++;
        fcnt[t]++;
      end
    end
    if (prv_pos == SVC_BASE + SVC_W - 1) begin
      if (el) begin
        chk(svc_bits == svc_of(prv_f), "R8", "service load", svc_bits, svc_of(prv_f));
        last_svc = svc_of(prv_f);
      end else begin
        chk(svc_bits == last_svc, "R8", "service hold", svc_bits, last_svc);
      end
    end
    if (prv_pos == 0) sync_start = locked;
    if (prv_pos == FL - 1) begin
      if (sync_start && locked)
        for (int t = 0; t < NT; t++)
          chk(fcnt[t] == DPT + (stf(t, prv_f) ? 0 : 1), "R7",
              $sformatf("lane %0d strobes per frame", t), fcnt[t], DPT + (stf(t, prv_f) ? 0 : 1));
      for (int t = 0; t < NT; t++) fcnt[t] = 0;
    end
  endtask

  task automatic tick(logic b, int f, int p);
    @(negedge clk);
    observe();
    line_bit = b;
    prv_f = f;
    prv_pos = p;
    have_prev = 1;
  endtask

  // mode 0: normal, 1: pattern inverted, 2: whole frame zero
  task automatic send_frame(int f, int mode);
    logic b;
    logic [SVC_W-1:0] sv;
    int t, k;
    sv = svc_of(f);
    for (int i = 0; i < NT; i++) base_idx[f][i] = txidx[i];
    for (int p = 0; p < FL; p++) begin
      if (p < FAW_W) b = (mode == 0) ? FAW[FAW_W-1-p] : (mode == 1) ? ~FAW[FAW_W-1-p] : 1'b0;
      else if (mode == 2) b = 1'b0;
      else if (p < CTL_BASE) b = sv[SVC_W-1-(p-SVC_BASE)];
      else if (p < STF_BASE) begin
        k = p - CTL_BASE;
        b = stf(k % NT, f) ^ ctl_err(k % NT, f, k / NT);
      end else if (p < DAT_BASE) begin
        t = p - STF_BASE;
        if (stf(t, f)) b = 1'b1;
        else begin b = src_bit(t, txidx[t]); txidx[t]++; end
      end else begin
        t = (p - DAT_BASE) % NT;
        b = src_bit(t, txidx[t]);
        txidx[t]++;
      end
      tick(b, f, p);
    end
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin txidx[t] = 0; rxidx[t] = 0; fcnt[t] = 0; end
    repeat (3) @(negedge clk);
    chk(locked == 0 && trib_vld == '0 && svc_bits == '0, "R1", "reset state",
        {locked, trib_vld, svc_bits}, 0);
    rst = 0;
    @(negedge clk);
    chk(locked == 0 && trib_vld == '0 && svc_bits == '0, "R1", "after release",
        {locked, trib_vld, svc_bits}, 0);
    for (int f = 0; f < NFR; f++) begin
      if (f == 27) send_frame(f, 2);
      else if ((f >= 20 && f <= 22) || (f >= 24 && f <= 26)) send_frame(f, 1);
      else send_frame(f, 0);
    end
    @(negedge clk);
    observe();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule